// File: doc/BRIEF.md
# Dual 16-bit packed multiply-add unit

This unit executes a single packed SIMD operation on 32-bit registers that each carry two 16-bit halves. An instruction word names three source registers and a destination in a 16-entry register file held inside the block. Two 16-bit products are formed from halves of the second and third sources. A 2-bit pairing field picks which halves meet in each product. A separate 2-bit field picks, for each lane on its own, whether that product is added to or subtracted from the matching half of the first source. The two lane results are packed and written to the destination.

Instructions arrive over a valid/ready handshake, one at a time. An accepted instruction produces a registered write-back beat one cycle later, and the register file takes the result on the clock edge that ends that beat. A load port fills the register file. An observation port reads any register combinationally, so the surrounding core, or a bench, can set up operands and inspect results.

Top module: `dmadl_unit`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0 and every register reads 0 through the observation port.
- R2: Instruction bits [5:0] hold the opcode and only 0x0C is executed. Its fields are the first source at [9:6], the second source at [13:10], the third source at [17:14], the destination at [21:18], the pairing at [23:22] and the add/sub select at [25:24]. An accepted 0x0C instruction raises `out_valid` for exactly one cycle, in the cycle after acceptance, with `out_idx` equal to the destination field.
- R3: Pairing selects the halves for each product. 0: high = B.hi×C.hi, low = B.lo×C.lo. 1: high = B.lo×C.hi, low = B.lo×C.lo. 2: high = B.hi×C.hi, low = B.hi×C.lo. 3: high = B.lo×C.hi, low = B.hi×C.lo.
- R4: Only the low 16 bits of each 32-bit product take part in the lane arithmetic.
- R5: Add/sub select: bit 1 set makes the high lane A.hi − product, otherwise A.hi + product. Bit 0 set makes the low lane A.lo − product, otherwise A.lo + product.
- R6: Each lane wraps modulo 2^16, and no carry or borrow passes between lanes.
- R7: The result {high lane, low lane} is in the destination register from the edge that ends the `out_valid` beat. No other register changes, and sources that are not also the destination keep their values.
- R8: An accepted instruction with any other opcode produces no `out_valid` and leaves every register unchanged.
- R9: Register 0 always reads 0. A write-back or load aimed at it is discarded, though a 0x0C instruction with destination 0 still gives its `out_valid` beat.
- R10: `in_ready` is 0 during the write-back cycle, and an instruction presented then is not taken.
- R11: A load (`ld_en`) writes `ld_data` into register `ld_idx` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| instr | input | 32 | Instruction word |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register to load |
| ld_data | input | 32 | Load value |
| peek_idx | input | 4 | Register to observe |
| peek_data | output | 32 | Current content of register `peek_idx` |
| out_valid | output | 1 | Write-back beat |
| out_idx | output | 4 | Destination of the write-back |
| out_data | output | 32 | Packed result being written |

## Verification
All sixteen combinations of pairing and add/sub select are applied to source registers whose four halves all differ, so a wrong half choice or a wrong lane sign changes the result. Operands of 0xFFFF and 0x8000 push products past 16 bits and lane sums past 2^16 or below zero, which separates truncation and wrap from carry leaking between lanes. Other opcodes, destination 0, a destination equal to a source, and an instruction held during the busy cycle each target a register whose later value shows whether it was touched.

// File: rtl/dmadl_pkg.sv
package dmadl_pkg;
  localparam int LANE_W = 16;
  localparam int LANES  = 2;
  localparam int XLEN   = LANE_W * LANES;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] OPC_DMADL = 6'h0C;

  typedef logic [LANE_W-1:0] half_t;
  typedef logic [IDX_W-1:0]  ridx_t;

  // packed to match instruction bits [25:0], opcode lowest
  typedef struct packed {
    logic [1:0]       addsub;
    logic [1:0]       pairing;
    ridx_t            rd;
    ridx_t            rc;
    ridx_t            rb;
    ridx_t            ra;
    logic [OPC_W-1:0] opc;
  } fields_t;

  // low half of the full product; signedness does not affect it
  function automatic half_t mul_lo(half_t a, half_t b);
    logic [2*LANE_W-1:0] full;
    full = a * b;
    return full[LANE_W-1:0];
  endfunction

  function automatic half_t lane_mix(half_t acc, half_t p, logic sub);
    return sub ? half_t'(acc - p) : half_t'(acc + p);
  endfunction
endpackage

// File: rtl/dmadl_decode.sv
module dmadl_decode
  import dmadl_pkg::*;
(
  input  logic [31:0] instr,
  output fields_t     fld,
  output logic        hit
);
  logic unused_rsvd;

  assign fld         = fields_t'(instr[$bits(fields_t)-1:0]);
  assign hit         = (fld.opc == OPC_DMADL);
  assign unused_rsvd = ^instr[31:$bits(fields_t)];
endmodule

// File: rtl/dmadl_lanes.sv
module dmadl_lanes
  import dmadl_pkg::*;
(
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] src_c,
  input  logic [1:0]      pairing,
  input  logic [1:0]      addsub,
  output logic [XLEN-1:0] prods,
  output logic [XLEN-1:0] result
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // lane i pairs C's own half with B's own half, or with
    // the opposite half of B when pairing[LANES-1-i] is set
    localparam int OTHER = LANES - 1 - i;
    half_t b_pick, c_half, a_half, p;

    assign b_pick = pairing[OTHER] ? src_b[OTHER*LANE_W +: LANE_W]
                                   : src_b[i*LANE_W +: LANE_W];
    assign c_half = src_c[i*LANE_W +: LANE_W];
    assign a_half = src_a[i*LANE_W +: LANE_W];
    assign p      = mul_lo(b_pick, c_half);

    assign prods[i*LANE_W +: LANE_W]  = p;
    assign result[i*LANE_W +: LANE_W] = lane_mix(a_half, p, addsub[i]);
  end
endmodule

// File: rtl/dmadl_regfile.sv
module dmadl_regfile #(
  parameter int NREG = 16,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_idx,
  input  logic [AW-1:0] rb_idx,
  input  logic [AW-1:0] rc_idx,
  input  logic [AW-1:0] rp_idx,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data,
  output logic [W-1:0]  rc_data,
  output logic [W-1:0]  rp_data,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] mem [1:NREG-1];

  function automatic logic [W-1:0] rd(logic [AW-1:0] a);
    return (a == '0) ? '0 : mem[a];
  endfunction

  assign ra_data = rd(ra_idx);
  assign rb_data = rd(rb_idx);
  assign rc_data = rd(rc_idx);
  assign rp_data = rd(rp_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < NREG; k++) mem[k] <= '0;
    end else if (we && wa != '0) begin
      mem[wa] <= wd;
    end
  end
endmodule

// File: rtl/dmadl_unit.sv
module dmadl_unit
  import dmadl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      instr,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [XLEN-1:0]  ld_data,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [XLEN-1:0]  peek_data,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [XLEN-1:0]  out_data
);
  fields_t         fld;
  logic            op_hit;
  logic            take;
  logic            take_hit;
  logic [XLEN-1:0] a_val, b_val, c_val;
  logic [XLEN-1:0] lane_prods;
  logic [XLEN-1:0] lane_res;

  logic            wb_pend;
  ridx_t           wb_idx;
  logic [XLEN-1:0] wb_data;

  logic            rf_we;
  ridx_t           rf_wa;
  logic [XLEN-1:0] rf_wd;

  dmadl_decode u_dec (
    .instr (instr),
    .fld   (fld),
    .hit   (op_hit)
  );

  dmadl_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (fld.ra),
    .rb_idx  (fld.rb),
    .rc_idx  (fld.rc),
    .rp_idx  (peek_idx),
    .ra_data (a_val),
    .rb_data (b_val),
    .rc_data (c_val),
    .rp_data (peek_data),
    .we      (rf_we),
    .wa      (rf_wa),
    .wd      (rf_wd)
  );

  dmadl_lanes u_lanes (
    .src_a   (a_val),
    .src_b   (b_val),
    .src_c   (c_val),
    .pairing (fld.pairing),
    .addsub  (fld.addsub),
    .prods   (lane_prods),
    .result  (lane_res)
  );

  assign in_ready = !wb_pend;
  assign take     = in_valid && in_ready;
  assign take_hit = take && op_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_pend <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      wb_pend <= take_hit;
      if (take_hit) begin
        wb_idx  <= fld.rd;
        wb_data <= lane_res;
      end
    end
  end

  // write-back has priority over the load port
  assign rf_we = wb_pend || ld_en;
  assign rf_wa = wb_pend ? wb_idx  : ld_idx;
  assign rf_wd = wb_pend ? wb_data : ld_data;

  assign out_valid = wb_pend;
  assign out_idx   = wb_idx;
  assign out_data  = wb_data;
endmodule

// File: rtl/dmadl_unit_chk.sv
module dmadl_unit_chk
  import dmadl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [31:0]      instr,
  input logic             take_hit,
  input logic [IDX_W-1:0] peek_idx,
  input logic [XLEN-1:0]  peek_data,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx,
  input logic [XLEN-1:0]  out_data
);
  logic take_any;
  assign take_any = in_valid && in_ready;

  assert_single_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_beat_follows_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(take_any && instr[5:0] == 6'h0C));

  assert_beat_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_hit |=> (out_valid && out_idx == $past(instr[21:18])));

  assert_foreign_opcode_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_any && instr[5:0] != 6'h0C) |=> !out_valid);

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_reg_zero_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_idx == '0) |-> (peek_data == '0));

  assert_commit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx != '0) |=>
      (peek_idx != $past(out_idx) || peek_data == $past(out_data)));
endmodule

bind dmadl_unit dmadl_unit_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .instr     (instr),
  .take_hit  (take_hit),
  .peek_idx  (peek_idx),
  .peek_data (peek_data),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .out_data  (out_data)
);

// File: tb/test_dmadl_unit.sv
module test_dmadl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  peek_idx = '0;
  logic [31:0] peek_data;
  logic        out_valid;
  logic [3:0]  out_idx;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] shadow [16];
  logic [35:0] expq [$];   // {idx, data}

  always #10 clk = ~clk;   // 50 MHz

  dmadl_unit i_dmadl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .peek_idx(peek_idx), .peek_data(peek_data), .out_valid(out_valid),
    .out_idx(out_idx), .out_data(out_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [5:0] opc, int ra, int rb, int rc,
                                     int rd, int pr, int as);
    return {6'b0, 2'(as), 2'(pr), 4'(rd), 4'(rc), 4'(rb), 4'(ra), opc};
  endfunction

  // reference written from the requirement tables
  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                        logic [31:0] c, int pr, int as);
    logic [15:0] bh, bl, ch, cl, mh, ml, hi, lo;
    logic [31:0] ph, pl;
    bh = b[31:16]; bl = b[15:0]; ch = c[31:16]; cl = c[15:0];
    case (pr)
      0: begin mh = bh; ml = bl; end
      1: begin mh = bl; ml = bl; end
      2: begin mh = bh; ml = bh; end
      default: begin mh = bl; ml = bh; end
    endcase
    ph = {16'b0, mh} * {16'b0, ch};
    pl = {16'b0, ml} * {16'b0, cl};
    hi = (as >= 2)     ? a[31:16] - ph[15:0] : a[31:16] + ph[15:0];
    lo = (as % 2 == 1) ? a[15:0]  - pl[15:0] : a[15:0]  + pl[15:0];
    return {hi, lo};
  endfunction

  task automatic load(int idx, logic [31:0] val);   // R11
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 4'(idx); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
    if (idx != 0) shadow[idx] = val;
  endtask

  task automatic peek(string req, int idx);
    peek_idx = 4'(idx);
    #1;
    check(req, peek_data, shadow[idx]);
  endtask

  task automatic issue(logic [31:0] w);
    logic [31:0] r;
    int d;
    d = int'(w[21:18]);
    if (w[5:0] == 6'h0C) begin
      r = model(shadow[w[9:6]], shadow[w[13:10]], shadow[w[17:14]],
                int'(w[23:22]), int'(w[25:24]));
      expq.push_back({w[21:18], r});
      if (d != 0) shadow[d] = r;
    end
    @(negedge clk);
    in_valid = 1'b1; instr = w;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops expected write-backs as they appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check("R8 unexpected write-back", {28'b0, out_idx}, 32'hFFFF_FFFF);
      end else begin
        logic [35:0] e;
        e = expq.pop_front();
        check("R2 out_idx", {28'b0, out_idx}, {28'b0, e[35:32]});
        check("R3 R4 R5 R6 out_data", out_data, e[31:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) shadow[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    for (int k = 0; k < 16; k++) peek("R1 reg after reset", k);

    load(1, 32'h1234_5678);
    load(2, 32'h0003_0005);
    load(3, 32'h0007_000B);
    load(4, 32'hFFFF_8000);
    load(5, 32'h8000_FFFF);
    load(6, 32'h0001_FFFE);
    load(0, 32'hDEAD_BEEF);
    peek("R11 load", 2);
    peek("R9 load to r0 ignored", 0);

    // R3 R5: every pairing with every add/sub select
    for (int pr = 0; pr < 4; pr++)
      for (int as = 0; as < 4; as++) begin
        issue(mk(6'h0C, 1, 2, 3, 7 + (pr * 4 + as) % 8, pr, as));
        peek("R7 dest written", 7 + (pr * 4 + as) % 8);
      end
    peek("R7 source A kept", 1);
    peek("R7 source B kept", 2);
    peek("R7 source C kept", 3);

    // R4 R6: large operands, truncation and lane wrap
    for (int as = 0; as < 4; as++) begin
      issue(mk(6'h0C, 6, 4, 5, 8, 3 - as, as));
      peek("R4 R6 wrap", 8);
      issue(mk(6'h0C, 4, 5, 5, 9, as, 3 - as));
      peek("R4 R6 wrap", 9);
    end

    // R7 destination equals first source
    issue(mk(6'h0C, 6, 2, 3, 6, 0, 0));
    peek("R7 dest same as source", 6);

    // R8 foreign opcodes
    issue(mk(6'h0D, 1, 2, 3, 10, 0, 0));
    issue(mk(6'h0B, 1, 2, 3, 10, 1, 1));
    issue(mk(6'h00, 1, 2, 3, 10, 2, 3));
    peek("R8 foreign opcode leaves reg", 10);

    // R9 destination 0
    issue(mk(6'h0C, 1, 2, 3, 0, 0, 0));
    peek("R9 r0 stays zero", 0);

    // R10 instruction held during busy cycle
    begin
      logic [31:0] r;
      r = model(shadow[1], shadow[4], shadow[3], 2, 1);
      expq.push_back({4'd11, r});
      shadow[11] = r;
      @(negedge clk);
      in_valid = 1'b1; instr = mk(6'h0C, 1, 4, 3, 11, 2, 1);
      @(negedge clk);
      check("R10 in_ready low while busy", {31'b0, in_ready}, 32'd0);
      instr = mk(6'h0C, 1, 2, 3, 12, 0, 0);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      peek("R10 busy-cycle instruction dropped", 12);
      peek("R7 first instruction written", 11);
    end

    repeat (3) @(negedge clk);
    check("R2 all write-backs seen", 32'(expq.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule